// File: doc/BRIEF.md
# Mono Audio Serial Port

This block moves 16-bit mono sample words between a codec's data path and a three-wire serial link. Words written on the parallel transmit side go out on a serial output pin, and words arriving on a serial input pin come back as parallel words with a one-cycle strobe. Every word is sent most significant bit first, in two's complement.

A two-bit format select chooses among four framings: a DSP framing with a one-bit-wide frame sync pulse, two MSB-justified framings, and an I2S-compatible framing. In DSP framing two extra controls apply: one inverts which bit-clock edge launches and which samples data, and one delays the whole word by half a bit clock. The port either drives the bit clock and frame clock itself (master), dividing them down from the system clock, or accepts both from outside (slave). In both cases it oversamples the serial clocks with the system clock.

Top module: `mono_audio_port`

## Requirements
- R1: fmt_sel encodes the framing: 2'b00 DSP, 2'b01 and 2'b10 MSB-justified, 2'b11 I2S. In MSB-justified framing the MSB is launched on the bit-clock edge where the frame clock rises, and the frame clock is high for the first half of the frame. In I2S framing the frame clock falls at frame start and stays low for the first half, and the MSB is launched one bit clock after that fall.
- R2: Each word is 16 bits, MSB first, two's complement. Bit slots after the 16th within a frame are driven 0 on ser_out and ignored on ser_in.
- R3: With master=1 the port drives bclk_o and fsync_o. The bit clock half period is half_div+1 system clocks, a frame is FRAME_BITS (default 32) bit clocks, and fsync_o changes only on a bit-clock edge. With master=0, bclk_o and fsync_o stay 0 and timing comes from bclk_i and fsync_i.
- R4: In formats 01, 10 and 11, ser_out changes after the falling bit-clock edge, ser_in is sampled on the rising edge, and the frame starts on a falling edge.
- R5: In DSP framing with dsp_edge_inv=0, data launches on the rising edge and is sampled on the falling edge. With dsp_edge_inv=1 both edges are swapped. The frame sync is high for exactly one bit clock and rises on a launch edge.
- R6: In DSP framing with dsp_half_shift=1, the whole word is moved half a bit clock later on both ser_out and ser_in. This still works in slave mode at 16 bit clocks per frame, where the LSB is sampled on the next frame's sync edge.
- R7: After the LSB of a received word is sampled, rx_data holds the word and rx_valid is high for exactly one cycle.
- R8: A tx_valid pulse stores tx_data. The stored word is taken at the start of each transmitted word, with a one-cycle tx_taken pulse. Without a new store, the same word is sent again.
- R9: rst_n is a synchronous active-low reset. During and after reset, bclk_o rests at the level opposite to the frame-start edge, fsync_o rests at its value before frame start (1 in I2S, 0 otherwise), and ser_out, rx_valid and tx_taken are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master | input | 1 | 1: generate serial clocks, 0: accept them |
| fmt_sel | input | 2 | Framing select (see R1) |
| dsp_edge_inv | input | 1 | DSP framing: swap launch and sample edges |
| dsp_half_shift | input | 1 | DSP framing: delay word by half a bit clock |
| half_div | input | DIV_W | Master bit-clock half period minus one, in system clocks |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Store tx_data |
| tx_taken | output | 1 | Stored word taken for transmission |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | rx_data updated this cycle |
| bclk_i | input | 1 | Bit clock in slave mode |
| fsync_i | input | 1 | Frame clock in slave mode |
| ser_in | input | 1 | Serial data in |
| bclk_o | output | 1 | Bit clock in master mode |
| fsync_o | output | 1 | Frame clock in master mode |
| ser_out | output | 1 | Serial data out |

## Verification
On every cycle the assertions check three things: the master bit-slot counter only steps by one or wraps, the generated frame clock never changes without a bit-clock edge, and the receive strobe is a single cycle that follows a slot event. They also check that the first launched bit of each word is its MSB. Only the bench scenarios can show the actual bit placement for each framing, edge polarity and half-bit shift, and the direction of the frame-start edge. The same holds for the frame sync width, zero padding, word repetition, and the slave-mode case where the LSB lands on the next sync edge. The bench decodes the serial output itself from the generated clocks and compares the result with the stored word.

// File: rtl/aport_pkg.sv
// Shared types and small decode helpers for the mono audio serial port.
// Assumes the framing select is static while the port runs.
package aport_pkg;

    typedef enum logic [1:0] {
        FMT_DSP  = 2'b00,
        FMT_LJ_A = 2'b01,
        FMT_LJ_B = 2'b10,
        FMT_I2S  = 2'b11
    } fmt_e;

    // Half-bit slot at which the MSB is launched, counted from frame start.
    function automatic logic [1:0] word_offset(fmt_e f, logic half_shift);
        logic [1:0] off;
        case (f)
            FMT_I2S: off = 2'd2;
            FMT_DSP: off = half_shift ? 2'd1 : 2'd0;
            default: off = 2'd0;
        endcase
        return off;
    endfunction

    // 1 when the frame-start bit-clock edge is a rising edge.
    function automatic logic start_edge_rises(fmt_e f, logic edge_inv);
        return (f == FMT_DSP) && !edge_inv;
    endfunction

endpackage

// File: rtl/aport_timing.sv
// Slot timing for the serial port. It keeps a half-bit slot counter.
// Master: a divider steps the counter and the clocks are decoded from it.
// Slave: the counter steps on every synchronized bit-clock edge and is
// cleared by the frame-start edge of the frame clock.
// Assumes half_div >= 2 in master mode and, in slave mode, at least 8
// system clocks per half bit clock.
module aport_timing
    import aport_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int DIV_W      = 8,
    parameter int TICK_W     = $clog2(2 * FRAME_BITS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  fmt_e              fmt,
    input  logic              edge_inv,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              bclk_i,
    input  logic              fsync_i,
    output logic [TICK_W-1:0] tick,
    output logic [TICK_W-1:0] cap_tick,
    output logic              adv,
    output logic              bclk_gen,
    output logic              fsync_gen
);
    localparam logic [TICK_W-1:0] LAST = TICK_W'(2 * FRAME_BITS - 1);
    localparam logic [TICK_W-1:0] HALF = TICK_W'(FRAME_BITS);
    localparam logic [TICK_W-1:0] SYNC = TICK_W'(2);

    logic [1:0]        bclk_sync, fsync_sync;
    logic              bclk_d, fsync_d;
    logic [DIV_W-1:0]  div_cnt;
    logic              m_step, s_step, s_align, step;
    logic [TICK_W-1:0] plus1, nxt, cap_nxt;

    // Step and frame-alignment decode for both clocking roles.
    always_comb begin
        m_step  = (div_cnt == half_div);
        s_step  = (bclk_sync[1] != bclk_d);
        s_align = (fmt == FMT_I2S) ? (fsync_d && !fsync_sync[1])
                                   : (!fsync_d && fsync_sync[1]);
        step    = master ? m_step : s_step;
        plus1   = tick + TICK_W'(1);
        if (master) begin
            nxt     = (tick == LAST) ? '0 : plus1;
            cap_nxt = nxt;
        end else begin
            nxt     = s_align ? '0 : ((tick == LAST) ? tick : plus1);
            cap_nxt = s_align ? plus1 : nxt;
        end
    end

    // Synchronizers, divider and slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_sync  <= '0;
            fsync_sync <= '0;
            bclk_d     <= 1'b0;
            fsync_d    <= 1'b0;
            div_cnt    <= '0;
            tick       <= LAST;
            cap_tick   <= LAST;
            adv        <= 1'b0;
        end else begin
            bclk_sync  <= {bclk_sync[0], bclk_i};
            fsync_sync <= {fsync_sync[0], fsync_i};
            bclk_d     <= bclk_sync[1];
            fsync_d    <= fsync_sync[1];
            div_cnt    <= (!master || m_step) ? '0 : div_cnt + DIV_W'(1);
            adv        <= step;
            if (step) begin
                tick     <= nxt;
                cap_tick <= cap_nxt;
            end
        end
    end

    // Master clock levels decoded from the slot counter.
    always_comb begin
        bclk_gen = tick[0] ^ start_edge_rises(fmt, edge_inv);
        case (fmt)
            FMT_DSP: fsync_gen = (tick < SYNC);
            FMT_I2S: fsync_gen = (tick >= HALF);
            default: fsync_gen = (tick < HALF);
        endcase
    end

    assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (master && adv) |-> (tick == '0 || tick == $past(tick) + TICK_W'(1)));

    assert_fsync_on_bclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !$stable(fsync_gen)) |-> !$stable(bclk_gen));

endmodule

// File: rtl/aport_tx.sv
// Transmit side. It holds the word written by the parallel side and
// launches one bit on each even slot counted from the word offset, MSB
// first. Slots past the word are driven 0.
// Assumes tick and adv come from aport_timing.
module aport_tx #(
    parameter int WORD_W = 16,
    parameter int TICK_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [TICK_W-1:0] tick,
    input  logic [1:0]        offset,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              ser_out,
    output logic              tx_taken
);
    localparam int IDX_W = TICK_W - 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LIM = IDX_W'(WORD_W);

    logic [WORD_W-1:0] hold, word;
    logic [TICK_W-1:0] off_t, rel;
    logic [IDX_W-1:0]  idx;
    logic [BIT_W-1:0]  bsel;
    logic              launch;

    // Launch slot decode.
    always_comb begin
        off_t  = {{(TICK_W-2){1'b0}}, offset};
        rel    = tick - off_t;
        idx    = rel[TICK_W-1:1];
        bsel   = BIT_W'(WORD_W - 1) - idx[BIT_W-1:0];
        launch = adv && (tick >= off_t) && !rel[0];
    end

    // Holding register, word register and serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= '0;
            word     <= '0;
            ser_out  <= 1'b0;
            tx_taken <= 1'b0;
        end else begin
            if (tx_valid) hold <= tx_data;
            tx_taken <= 1'b0;
            if (launch) begin
                if (idx == '0) begin
                    word     <= hold;
                    ser_out  <= hold[WORD_W-1];
                    tx_taken <= 1'b1;
                end else if (idx < LIM) begin
                    ser_out <= word[bsel];
                end else begin
                    ser_out <= 1'b0;
                end
            end
        end
    end

    assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_taken |-> (ser_out == word[WORD_W-1]));

endmodule

// File: rtl/aport_rx.sv
// Receive side. It synchronizes the serial input and samples it on each
// odd slot counted from the word offset. After the last bit it presents
// the word with a one-cycle strobe. Slots past the word are ignored.
// Assumes cap_tick and adv come from aport_timing.
module aport_rx #(
    parameter int WORD_W = 16,
    parameter int TICK_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [TICK_W-1:0] cap_tick,
    input  logic [1:0]        offset,
    input  logic              ser_in,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int IDX_W = TICK_W - 1;
    localparam logic [IDX_W-1:0] LIM      = IDX_W'(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    logic [1:0]        in_sync;
    logic [WORD_W-1:0] shreg;
    logic [TICK_W-1:0] off_t, rel;
    logic [IDX_W-1:0]  idx;
    logic              capture;

    // Sample slot decode.
    always_comb begin
        off_t   = {{(TICK_W-2){1'b0}}, offset};
        rel     = cap_tick - off_t;
        idx     = rel[TICK_W-1:1];
        capture = adv && (cap_tick >= off_t) && rel[0] && (idx < LIM);
    end

    // Input synchronizer, shift register and word output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sync  <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            in_sync  <= {in_sync[0], ser_in};
            rx_valid <= 1'b0;
            if (capture) begin
                shreg <= {shreg[WORD_W-2:0], in_sync[1]};
                if (idx == LAST_IDX) begin
                    rx_data  <= {shreg[WORD_W-2:0], in_sync[1]};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_valid_after_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(adv));

endmodule

// File: rtl/mono_audio_port.sv
// Mono audio serial port top. It joins slot timing, transmit and receive,
// and gates the clock outputs to 0 in slave mode.
// Assumes the mode inputs only change while rst_n is low.
module mono_audio_port
    import aport_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int FRAME_BITS = 32,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic [1:0]        fmt_sel,
    input  logic              dsp_edge_inv,
    input  logic              dsp_half_shift,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_taken,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              ser_in,
    output logic              bclk_o,
    output logic              fsync_o,
    output logic              ser_out
);
    localparam int TICK_W = $clog2(2 * FRAME_BITS) + 1;

    fmt_e              fmt;
    logic [1:0]        offset;
    logic [TICK_W-1:0] tick, cap_tick;
    logic              adv, bclk_gen, fsync_gen;

    // Mode decode and clock output gating.
    always_comb begin
        fmt     = fmt_e'(fmt_sel);
        offset  = word_offset(fmt, dsp_half_shift);
        bclk_o  = master && bclk_gen;
        fsync_o = master && fsync_gen;
    end

    aport_timing #(.FRAME_BITS(FRAME_BITS), .DIV_W(DIV_W), .TICK_W(TICK_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .master(master), .fmt(fmt),
        .edge_inv(dsp_edge_inv), .half_div(half_div),
        .bclk_i(bclk_i), .fsync_i(fsync_i),
        .tick(tick), .cap_tick(cap_tick), .adv(adv),
        .bclk_gen(bclk_gen), .fsync_gen(fsync_gen)
    );

    aport_tx #(.WORD_W(WORD_W), .TICK_W(TICK_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .adv(adv), .tick(tick), .offset(offset),
        .tx_data(tx_data), .tx_valid(tx_valid),
        .ser_out(ser_out), .tx_taken(tx_taken)
    );

    aport_rx #(.WORD_W(WORD_W), .TICK_W(TICK_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .adv(adv), .cap_tick(cap_tick), .offset(offset),
        .ser_in(ser_in), .rx_data(rx_data), .rx_valid(rx_valid)
    );

endmodule

// File: tb/mono_audio_port_tb.sv
module mono_audio_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1;
    logic [1:0]  cfg_fmt = 2'b01;
    logic        cfg_inv = 1'b0;
    logic        cfg_shift = 1'b0;
    logic [7:0]  half_div = 8'd3;
    logic [15:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        drv_bclk = 1'b0, drv_fsync = 1'b0, drv_ser = 1'b0;
    logic        tx_taken, rx_valid, bclk_o, fsync_o, ser_out, ser_in;
    logic [15:0] rx_data;

    always #10 clk = ~clk;

    assign ser_in = cfg_master ? ser_out : drv_ser;

    mono_audio_port u_dut (
        .clk(clk), .rst_n(rst_n), .master(cfg_master), .fmt_sel(cfg_fmt),
        .dsp_edge_inv(cfg_inv), .dsp_half_shift(cfg_shift), .half_div(half_div),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_taken(tx_taken),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .bclk_i(drv_bclk), .fsync_i(drv_fsync), .ser_in(ser_in),
        .bclk_o(bclk_o), .fsync_o(fsync_o), .ser_out(ser_out)
    );

    // {fmt[1:0], edge_inv, half_shift, word[15:0]}
    localparam logic [19:0] VEC [0:7] = '{
        20'h0A5C3, 20'h28000, 20'h17FFF, 20'h31234,
        20'h4FFFF, 20'h80F0F, 20'hCC001, 20'hC0001
    };

    int total = 0, fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Independent decoder of the generated serial stream (first frame).
    logic        dec_clear = 1'b1;
    logic        exp_rise;
    int          exp_off;
    int          dt, hi_cnt, zero_err, rel, bi;
    logic        pb, pf, edge_ok, fedge;
    logic [15:0] dword;

    assign exp_rise = (cfg_fmt == 2'b00) && !cfg_inv;
    assign exp_off  = (cfg_fmt == 2'b11) ? 2 : ((cfg_fmt == 2'b00 && cfg_shift) ? 1 : 0);

    always @(negedge clk) begin
        if (dec_clear) begin
            dt = -1; hi_cnt = 0; zero_err = 0; edge_ok = 1'b0; dword = '0;
        end else if (bclk_o != pb) begin
            fedge = (cfg_fmt == 2'b11) ? (pf && !fsync_o) : (!pf && fsync_o);
            if (dt < 0) begin
                if (fedge) begin
                    dt = 0;
                    edge_ok = (bclk_o == exp_rise);
                end
            end else begin
                dt++;
            end
            if (dt >= 0 && dt < 64) begin
                if (fsync_o) hi_cnt++;
                rel = dt - exp_off;
                if (rel >= 0 && rel % 2 == 1) begin
                    bi = rel / 2;
                    if (bi < 16) dword[15 - bi] = ser_out;
                    else if (ser_out) zero_err++;
                end
            end
        end
        pb = bclk_o;
        pf = fsync_o;
    end

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (rx_valid) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic start(input logic m, input logic [1:0] f, input logic inv,
                         input logic sh, input logic [15:0] w);
        @(negedge clk);
        rst_n = 1'b0; dec_clear = 1'b1;
        cfg_master = m; cfg_fmt = f; cfg_inv = inv; cfg_shift = sh;
        drv_bclk = 1'b0; drv_fsync = 1'b0; drv_ser = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; dec_clear = 1'b0;
        tx_data = w; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic run_master(input logic [19:0] v);
        bit s1, s2;
        logic [15:0] w;
        logic [15:0] r1;
        string rq;
        w = v[15:0];
        start(1'b1, v[19:18], v[17], v[16], w);
        wait_valid(s1);
        r1 = rx_data;
        check(s1 && r1 == w, "R7", "loopback word", r1, w);
        wait_valid(s2);
        check(s2 && rx_data == w, "R8", "repeated word", rx_data, w);
        rq = (v[19:18] == 2'b00 && v[16]) ? "R6" : "R1";
        check(dword == w, rq, "decoded ser_out word", dword, w);
        rq = (v[19:18] == 2'b00) ? "R5" : "R4";
        check(edge_ok == 1'b1, rq, "frame-start bclk edge direction", edge_ok, 1);
        rq = (v[19:18] == 2'b00) ? "R5" : "R1";
        check(hi_cnt == ((v[19:18] == 2'b00) ? 2 : 32), rq, "fsync high half-bits",
              hi_cnt, (v[19:18] == 2'b00) ? 2 : 32);
        check(zero_err == 0, "R2", "padding slots nonzero", zero_err, 0);
    endtask

    task automatic run_slave_dsp_shift();
        logic [15:0] w;
        int nval, nbad, leak;
        w = 16'h5A3C;
        start(1'b0, 2'b00, 1'b0, 1'b1, 16'h0);
        nval = 0; nbad = 0; leak = 0;
        for (int t = 0; t < 98; t++) begin
            int tt, r;
            tt = t % 32;
            r = tt - 1;
            drv_bclk  = (tt % 2 == 0);
            drv_fsync = (tt < 2);
            if (r >= 0 && r % 2 == 0 && r / 2 < 16) drv_ser = w[15 - r / 2];
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (bclk_o || fsync_o) leak++;
                if (rx_valid) begin
                    nval++;
                    if (rx_data != w) nbad++;
                end
            end
        end
        check(nval == 3, "R6", "slave 16fs shifted word count", nval, 3);
        check(nbad == 0, "R6", "slave shifted word mismatches", nbad, 0);
        check(leak == 0, "R3", "slave clock outputs not quiet", leak, 0);
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        fork
            begin
                // R9: reset levels, MSB-justified then I2S.
                cfg_master = 1'b1; cfg_fmt = 2'b01;
                repeat (3) @(negedge clk);
                check(bclk_o == 1'b1 && fsync_o == 1'b0, "R9", "reset clocks fmt01",
                      {bclk_o, fsync_o}, 2'b10);
                check(ser_out == 1'b0 && rx_valid == 1'b0 && tx_taken == 1'b0, "R9",
                      "reset outputs", {ser_out, rx_valid, tx_taken}, 0);
                cfg_fmt = 2'b11;
                @(negedge clk);
                check(fsync_o == 1'b1, "R9", "reset fsync fmt11", fsync_o, 1);
                for (int i = 0; i < 8; i++) run_master(VEC[i]);
                run_slave_dsp_shift();
            end
            begin
                repeat (100000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            total++; fails++;
            $display("FAIL watchdog: actual expired expected finished");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule